// File: doc/BRIEF.md
# Serial Control Port Register File

This block is a three-wire serial slave that holds five control registers of unequal length. A host frames each transaction by pulling an active-low select line low. It then clocks in a header on the serial clock: a direction flag, a three-bit register address sent least significant bit first, and a test flag. Data bits follow. The serial clock, select and data input are brought into the core clock domain through two-flop synchronizers, and every edge is detected there.

Writes go into shadow registers one register at a time. A shadow register is loaded only when all of its bits have arrived. A burst continues into the next address with no new header. The live registers, which drive the parallel outputs, take the shadow contents together when select rises. A read shifts the live value of the addressed register out on the data output, with an output enable that marks the cycles in which the line is driven.

Top module: `serial_ctl_regs`

## Requirements
- R1: After reset the outputs read op=0x080, gain=0, clamp=0, ctrl=0, gain2=0, and the output enable is low.
- R2: A frame is the direction flag (0 = write, 1 = read), then address bits 0, 1 and 2, then the test flag, then data least significant bit first. Every bit is sampled on a rising serial clock edge. The register lengths are 11 bits at address 0 (op), 10 at 1 (gain), 8 at 2 (clamp), 10 at 3 (ctrl) and 10 at 4 (gain2).
- R3: The parallel outputs do not change while a write frame is in progress. All registers completed in the frame update together when select rises.
- R4: In a write burst, each register consumes exactly its own length, and the next bits load the next higher address.
- R5: Bits that a burst sends beyond address 4 are ignored, and the burst does not wrap around to address 0.
- R6: A register whose bits are cut short when select rises keeps its previous value.
- R7: A write frame is ignored if its test flag is 1 or its address is 5, 6 or 7.
- R8: In a read, the output enable rises after the fifth falling serial clock edge with bit 0 of the live register on the data output. The output moves to the next bit on each later falling edge. The enable drops on the falling edge that follows the last bit.
- R9: The output enable is low during write frames, while select is high, and during reads that have the test flag set or address 5 to 7.
- R10: op bit 7 always reads 1. op bits 5, 8, 9 and 10 and ctrl bits 0, 1 and 2 always read 0, whatever value is written.
- R11: Raising select partway through a header discards that header, and the next frame decodes from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock |
| sel_n_i | input | 1 | Active-low frame select; its rising edge commits the frame |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out, meaningful only while sdo_oe_o is high |
| sdo_oe_o | output | 1 | Output enable for the data line |
| op_o | output | 11 | Live register at address 0 |
| gain_o | output | 10 | Live register at address 1 |
| clamp_o | output | 8 | Live register at address 2 |
| ctrl_o | output | 10 | Live register at address 3 |
| gain2_o | output | 10 | Live register at address 4 |

## Verification
The hardest situations to reach from the ports are the register boundaries inside a long burst: a burst that runs past the last address, and a frame cut off partway through a register. The bench builds bursts bit by bit from a list of values. It sends a burst that starts at address 3 and carries a third register's worth of bits, and a burst from address 0 that stops four bits into address 1. Its model updates a register only when all of that register's bits were sent. It also checks that every output still holds its old value just before select rises.

// File: rtl/serial_ctl_regs.sv
module serial_ctl_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sck_i,
  input  logic        sel_n_i,
  input  logic        sdi_i,
  output logic        sdo_o,
  output logic        sdo_oe_o,
  output logic [10:0] op_o,
  output logic [9:0]  gain_o,
  output logic [7:0]  clamp_o,
  output logic [9:0]  ctrl_o,
  output logic [9:0]  gain2_o
);
  localparam int NREG = 5;
  localparam int W    = 11;
  localparam int HDR  = 5;
  localparam int TOT  = 49;

  function automatic logic [3:0] rlen(input logic [2:0] a);
    case (a)
      3'd0:    rlen = 4'd11;
      3'd2:    rlen = 4'd8;
      default: rlen = 4'd10;
    endcase
  endfunction

  function automatic logic [5:0] roff(input logic [2:0] a);
    case (a)
      3'd0:    roff = 6'd0;
      3'd1:    roff = 6'd11;
      3'd2:    roff = 6'd21;
      3'd3:    roff = 6'd29;
      default: roff = 6'd39;
    endcase
  endfunction

  function automatic logic [W-1:0] keep1(input logic [2:0] a);
    keep1 = (a == 3'd0) ? 11'h080 : 11'h000;
  endfunction

  function automatic logic [W-1:0] keep0(input logic [2:0] a);
    case (a)
      3'd0:    keep0 = 11'h720;
      3'd2:    keep0 = 11'h700;
      3'd3:    keep0 = 11'h407;
      default: keep0 = 11'h400;
    endcase
  endfunction

  logic [2:0] sck_s, sel_s;
  logic [1:0] sdi_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_s <= '0;
      sel_s <= '1;
      sdi_s <= '0;
    end else begin
      sck_s <= {sck_s[1:0], sck_i};
      sel_s <= {sel_s[1:0], sel_n_i};
      sdi_s <= {sdi_s[0], sdi_i};
    end

  wire sck_rise = sck_s[1] & ~sck_s[2];
  wire sck_fall = ~sck_s[1] & sck_s[2];
  wire sel_low  = ~sel_s[1];
  wire sel_rise = sel_s[1] & ~sel_s[2];
  wire bit_in   = sdi_s[1];

  logic [2:0]   hcnt, fcnt, addr, cur;
  logic         rnw, tbit, oe;
  logic [3:0]   bidx, ridx;
  logic [W-1:0] acc;
  logic [TOT-1:0] shad_flat, live_flat;

  wire          in_data = (hcnt == 3'(HDR));
  wire          wr_ok   = !rnw && !tbit && (cur < 3'(NREG));
  wire [W-1:0]  acc_nx  = acc | (W'(bit_in) << bidx);
  wire          reg_end = (bidx == rlen(cur) - 4'd1);
  wire          load    = sel_low && sck_rise && in_data && wr_ok && reg_end;

  always_ff @(posedge clk)
    if (!sel_low) begin
      hcnt <= '0; fcnt <= '0; addr <= '0; cur <= '0;
      rnw  <= 1'b0; tbit <= 1'b0; oe <= 1'b0;
      bidx <= '0; ridx <= '0; acc <= '0;
    end else begin
      if (sck_rise) begin
        if (!in_data) begin
          case (hcnt)
            3'd0:    rnw     <= bit_in;
            3'd1:    addr[0] <= bit_in;
            3'd2:    addr[1] <= bit_in;
            3'd3:    addr[2] <= bit_in;
            default: tbit    <= bit_in;
          endcase
          if (hcnt == 3'd3) cur <= {bit_in, addr[1:0]};
          hcnt <= hcnt + 3'd1;
        end else if (wr_ok) begin
          if (reg_end) begin
            acc  <= '0;
            bidx <= '0;
            cur  <= cur + 3'd1;
          end else begin
            acc  <= acc_nx;
            bidx <= bidx + 4'd1;
          end
        end
      end
      if (sck_fall) begin
        if (fcnt != 3'(HDR)) begin
          fcnt <= fcnt + 3'd1;
          if (fcnt == 3'(HDR - 1) && rnw && !tbit && addr < 3'(NREG)) begin
            oe   <= 1'b1;
            ridx <= '0;
          end
        end else if (oe) begin
          if (ridx == rlen(addr) - 4'd1) oe <= 1'b0;
          else ridx <= ridx + 4'd1;
        end
      end
    end

  for (genvar g = 0; g < NREG; g++) begin : gen_reg
    localparam int       LEN = int'(rlen(3'(g)));
    localparam int       OFF = int'(roff(3'(g)));
    localparam [W-1:0]   K1  = keep1(3'(g));
    localparam [W-1:0]   K0  = keep0(3'(g));
    logic [LEN-1:0] sh, lv;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        sh <= K1[LEN-1:0];
        lv <= K1[LEN-1:0];
      end else begin
        if (load && cur == 3'(g)) sh <= acc_nx[LEN-1:0];
        if (sel_rise) lv <= (sh & ~K0[LEN-1:0]) | K1[LEN-1:0];
      end

    assign shad_flat[OFF +: LEN] = sh;
    assign live_flat[OFF +: LEN] = lv;
  end

  assign sdo_oe_o = oe;
  assign sdo_o    = oe ? live_flat[roff(addr) + {2'b00, ridx}] : 1'b0;
  assign op_o     = live_flat[10:0];
  assign gain_o   = live_flat[20:11];
  assign clamp_o  = live_flat[28:21];
  assign ctrl_o   = live_flat[38:29];
  assign gain2_o  = live_flat[48:39];
endmodule

// File: rtl/serial_ctl_regs_chk.sv
module serial_ctl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sel_n_i,
  input logic        sel_rise,
  input logic        sck_fall,
  input logic        rnw,
  input logic        tbit,
  input logic        oe,
  input logic [2:0]  hcnt,
  input logic [48:0] shad_flat,
  input logic [48:0] live_flat
);
  a_r3_live_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (live_flat != $past(live_flat)) |-> $past(sel_rise));

  a_r7_shadow_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (shad_flat != $past(shad_flat)) |-> $past(!rnw && !tbit && hcnt == 3'd5));

  a_r9_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> (rnw && !tbit));

  a_r8_oe_drop_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe) |-> ($past(sck_fall) || $past(sel_rise)));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n_i && $past(sel_n_i) && $past(sel_n_i, 2) && $past(sel_n_i, 3)) |-> !oe);
endmodule

bind serial_ctl_regs serial_ctl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n_i), .sel_rise(sel_rise),
  .sck_fall(sck_fall), .rnw(rnw), .tbit(tbit), .oe(oe), .hcnt(hcnt),
  .shad_flat(shad_flat), .live_flat(live_flat)
);

// File: tb/serial_ctl_regs_bench.sv
module serial_ctl_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, sel_n = 1'b1, sdi = 1'b0;
  logic sdo, oe;
  logic [10:0] op; logic [9:0] gain; logic [7:0] clamp; logic [9:0] ctrl; logic [9:0] gain2;

  serial_ctl_regs u_serial_ctl_regs (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .sel_n_i(sel_n), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(oe), .op_o(op), .gain_o(gain), .clamp_o(clamp),
    .ctrl_o(ctrl), .gain2_o(gain2));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int kind; logic [10:0] val; string req; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;
  logic [10:0] exp_r[5], pv[5], wv[8];
  bit pend[5];

  function automatic int len(int a);
    return (a == 0) ? 11 : (a == 2) ? 8 : 10;
  endfunction
  function automatic logic [10:0] k1(int a);
    return (a == 0) ? 11'h080 : 11'h000;
  endfunction
  function automatic logic [10:0] k0(int a);
    case (a) 0: return 11'h720; 2: return 11'h700; 3: return 11'h407; default: return 11'h400; endcase
  endfunction
  function automatic logic [10:0] act_reg(int i);
    case (i) 0: return op; 1: return 11'(gain); 2: return 11'(clamp); 3: return 11'(ctrl); default: return 11'(gain2); endcase
  endfunction

  initial forever begin
    item_t it; logic [10:0] act;
    wait (q.size() != 0);
    it = q.pop_front();
    if (it.kind == 0) act = {9'd0, oe, sdo};
    else if (it.kind == 1) act = {10'd0, oe};
    else act = act_reg(it.kind - 2);
    if (it.kind == 0) it.val = {9'd0, 1'b1, it.val[0]};
    checks++;
    if (act !== it.val) begin
      fails++;
      $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.val);
    end
  end

  task automatic push(int kind, logic [10:0] v, string req);
    item_t it; it.kind = kind; it.val = v; it.req = req; q.push_back(it);
  endtask
  task automatic push_regs(string req);
    for (int i = 0; i < 5; i++) push(2 + i, exp_r[i], req);
  endtask
  task automatic sbit(logic b);
    sdi = b; repeat (H) @(negedge clk); sck = 1'b1; repeat (H) @(negedge clk); sck = 1'b0;
  endtask
  task automatic header(logic r, int a, logic t);
    sel_n = 1'b0; repeat (H) @(negedge clk);
    sbit(r); sbit(a[0]); sbit(a[1]); sbit(a[2]); sbit(t);
  endtask
  task automatic commit(string req);
    repeat (H) @(negedge clk); sel_n = 1'b1; repeat (8) @(negedge clk);
    for (int i = 0; i < 5; i++) if (pend[i]) begin
      exp_r[i] = (pv[i] & ~k0(i)) | k1(i); pend[i] = 0;
    end
    push_regs(req);
  endtask
  task automatic wr(int a, logic t, int nbits, string req);
    int r = a, j = 0, k = 0;
    header(1'b0, a, t);
    for (int n = 0; n < nbits; n++) begin
      int l = (r < 5) ? len(r) : 10;
      sbit(wv[k][j]);
      j++;
      if (j == l) begin
        if (!t && r < 5) begin pend[r] = 1; pv[r] = wv[k]; end
        r++; k++; j = 0;
      end
    end
    repeat (5) @(negedge clk);
    push(1, 11'd0, "R9 oe low in write");
    push_regs("R3 unchanged before strobe");
    commit(req);
  endtask
  task automatic rd(int a, logic t, string req);
    int l = (a < 5) ? len(a) : 10;
    bit good = (a < 5) && !t;
    header(1'b1, a, t);
    repeat (5) @(negedge clk);
    if (good) push(0, 11'(exp_r[a][0]), req); else push(1, 11'd0, "R9 no drive");
    for (int i = 1; i < l; i++) begin
      sbit(1'b0); repeat (5) @(negedge clk);
      if (good) push(0, 11'(exp_r[a][i]), req);
    end
    sbit(1'b0); repeat (5) @(negedge clk);
    push(1, 11'd0, good ? "R8 oe drops after last bit" : "R9 no drive");
    repeat (H) @(negedge clk); sel_n = 1'b1; repeat (8) @(negedge clk);
    push(1, 11'd0, "R9 oe low when idle");
  endtask

  initial begin
    for (int i = 0; i < 5; i++) begin exp_r[i] = k1(i); pend[i] = 0; end
    repeat (4) @(negedge clk); rst_n = 1'b1; repeat (4) @(negedge clk);
    push_regs("R1 reset"); push(1, 11'd0, "R1 oe low");

    wv[0] = 11'h0A5; wr(2, 1'b0, 8, "R2 single write");

    wv[0] = 11'h7FF; wv[1] = 11'h155; wv[2] = 11'h03C; wv[3] = 11'h3FF; wv[4] = 11'h2AA;
    wr(0, 1'b0, 49, "R4 burst, R10 reserved bits");

    wv[0] = 11'h123; wv[1] = 11'h0F0; wv[2] = 11'h3FF;
    wr(3, 1'b0, 30, "R5 burst past end");

    wv[0] = 11'h6A9; wv[1] = 11'h3FF;
    wr(0, 1'b0, 15, "R6 partial register");

    wv[0] = 11'h3C3; wr(1, 1'b1, 10, "R7 test flag high");
    wv[0] = 11'h3C3; wr(6, 1'b0, 10, "R7 bad address");

    rd(0, 1'b0, "R8 read op");
    rd(2, 1'b0, "R8 read clamp");
    rd(4, 1'b0, "R8 read gain2");
    rd(1, 1'b1, "R9 read test flag");
    rd(5, 1'b0, "R9 read bad address");

    sel_n = 1'b0; repeat (H) @(negedge clk);
    sbit(1'b1); sbit(1'b1); sbit(1'b0);
    commit("R11 abort keeps values");
    wv[0] = 11'h05A; wr(2, 1'b0, 8, "R11 clean decode after abort");

    wait (q.size() == 0); #1;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule